// File: doc/BRIEF.md
# Ethernet PHY Serial Management Register Slave

This block is the management side of an Ethernet physical-layer device. It listens on the two-wire management bus (clock MDC, bidirectional data MDIO) and decodes standard clause-22 frames. Each frame has a preamble of ones, a start pattern, a two-bit opcode, a PHY address, a register address, a turnaround and sixteen data bits. Writes update a small register set. Reads return register contents on MDIO, most significant bit first.

The register set has four standard words: control, status and two identifier words. It also has a window of general-purpose vendor words at addresses 16 to 22. The block answers at its strapped PHY address. For the four standard words only, it also answers at the broadcast address zero. The control word drives the device's speed, auto-negotiation enable, duplex, loopback, power-down and isolate outputs. The status word reports strap-configured abilities, link state and auto-negotiation completion, all taken from input ports.

MDC and MDIO are oversampled in the system clock domain. Every output is registered.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones on MDIO, each sampled on a rising MDC edge, followed by the bits 0 then 1. Opcode bits 10 mean read and 01 mean write. Any other opcode, and any frame with a shorter run of ones, is ignored and leaves every register unchanged.
- R2: In a read the block releases MDIO during the first turnaround bit and drives 0 for the second. It then drives the 16 data bits, most significant first, one bit per MDC rising edge, and releases MDIO after the last bit. MDIO output and enable change only after a rising MDC edge.
- R3: The strapped PHY address reaches every implemented register. Address 00000 reaches only registers 0 to 3. A broadcast read of a vendor register leaves MDIO undriven, and a broadcast write to one has no effect. Any other address is ignored.
- R4: A read of an unimplemented register (4 to 15, 23 to 31) leaves MDIO undriven for the whole frame, and a write to one has no effect.
- R5: Control bit 13 selects speed, where 1 means 100 Mb/s. It resets to 1. A write changes it only when all three technology strap inputs are 0 and control bit 12 (auto-negotiation enable, reset value 1) held 0 before that write. Otherwise the old value is kept.
- R6: The other writable control bits are 14 (loopback), 12 (auto-negotiation enable), 11 (power-down), 10 (isolate) and 8 (full duplex). Each drives its own output port. All reset to 0 except bit 12. Frames are still answered while power-down or isolate is set.
- R7: Writing 1 to control bit 15 restores every register, vendor words included, to its reset value. Bit 15 always reads 0.
- R8: The status word (register 1) reads as follows. Bit 15 is 0. Bits 14, 13 and 12 equal technology straps 2, 1 and 0. Bits 11, 3 and 0 are 1. Bit 5 is the auto-negotiation-complete input and bit 2 is the link input. All other bits are 0. Control writes never alter it.
- R9: Register 2 returns the upper identifier parameter (default 0x2A5C). Register 3 returns the 6 low identifier bits (default 0x15), then the model number 0x0C, then the revision 0x9, giving 0x54C9 by default.
- R10: Registers 16 to 22 are 16-bit read/write words that reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the MDC rate |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock |
| mdio_i | input | 1 | MDIO value seen on the bus |
| mdio_o | output | 1 | MDIO value driven during read data |
| mdio_oe | output | 1 | MDIO output enable |
| phy_addr | input | 5 | Strapped PHY address |
| tech_strap | input | 3 | Technology ability straps |
| link_up | input | 1 | Link status from the line side |
| an_done | input | 1 | Auto-negotiation complete |
| speed100 | output | 1 | 1 selects 100 Mb/s |
| an_enable | output | 1 | Auto-negotiation enable |
| full_duplex | output | 1 | Full duplex select |
| loopback | output | 1 | Loopback select |
| power_down | output | 1 | Power-down request |
| isolate | output | 1 | Isolate request |

## Verification
The bench builds the block with the preamble length of 32, two synchronizer stages, seven vendor words from address 16, and identifier values it passes explicitly. With these values, a frame whose preamble has exactly 31 ones is rejected while one with 32 is accepted. Register 22 is the last vendor word and register 23 is the first unimplemented address above the window. The strap straps are moved between non-zero and zero mid-run, so both sides of the speed write lock are exercised, as well as the held auto-negotiation value that gates it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W = 16;
  localparam int ADR_W = 5;

  localparam logic [1:0] OPC_WR = 2'b01;
  localparam logic [1:0] OPC_RD = 2'b10;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_SFD,
    ST_HDR,
    ST_TA,
    ST_DAT
  } mdio_st_e;

  typedef struct packed {
    logic loopback;
    logic speed100;
    logic an_en;
    logic pwrdn;
    logic isolate;
    logic duplex;
  } ctl_t;

  localparam ctl_t CTL_DEF = 6'b011000;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc,
  input  logic mdio_i,
  output logic rise,
  output logic bit_q
);
  logic [STAGES-1:0] mdc_sr;
  logic [STAGES-1:0] dat_sr;
  logic              mdc_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_sr   <= '0;
      dat_sr   <= '1;
      mdc_last <= 1'b0;
      rise     <= 1'b0;
      bit_q    <= 1'b1;
    end else begin
      mdc_sr   <= {mdc_sr[STAGES-2:0], mdc};
      dat_sr   <= {dat_sr[STAGES-2:0], mdio_i};
      mdc_last <= mdc_sr[STAGES-1];
      rise     <= mdc_sr[STAGES-1] & ~mdc_last;
      bit_q    <= dat_sr[STAGES-1];
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             bit_i,
  input  logic [ADR_W-1:0] phy_addr,
  input  logic             rd_hit,
  input  logic [REG_W-1:0] rd_data,
  output logic [ADR_W-1:0] reg_a,
  output logic             sel_own,
  output logic             sel_bcast,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_data,
  output logic             mdio_o,
  output logic             mdio_oe
);
  localparam int HDR_BITS = 2 + 2 * ADR_W;
  localparam int ONES_W   = $clog2(PRE_LEN + 1);
  localparam int CNT_W    = $clog2(HDR_BITS + REG_W + 1);
  localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(PRE_LEN);
  localparam logic [CNT_W-1:0]  HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0]  DAT_LAST = CNT_W'(REG_W - 1);

  mdio_st_e            st;
  logic [ONES_W-1:0]   ones;
  logic [CNT_W-1:0]    bcnt;
  logic [HDR_BITS-2:0] hdr;
  logic [HDR_BITS-1:0] hdr_nx;
  logic [1:0]          op_q;
  logic [REG_W-1:0]    sh;
  logic                rd_go;
  logic [1:0]          op_nx;
  logic [ADR_W-1:0]    pa_nx;

  assign hdr_nx = {hdr, bit_i};
  assign op_nx  = hdr_nx[HDR_BITS-1 -: 2];
  assign pa_nx  = hdr_nx[2*ADR_W-1 -: ADR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PRE;
      ones      <= '0;
      bcnt      <= '0;
      hdr       <= '0;
      op_q      <= '0;
      reg_a     <= '0;
      sel_own   <= 1'b0;
      sel_bcast <= 1'b0;
      sh        <= '0;
      rd_go     <= 1'b0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (rise) begin
        unique case (st)
          ST_PRE: begin
            if (bit_i) begin
              if (ones != ONES_MAX) ones <= ones + 1'b1;
            end else begin
              if (ones == ONES_MAX) st <= ST_SFD;
              ones <= '0;
            end
          end
          ST_SFD: begin
            st   <= bit_i ? ST_HDR : ST_PRE;
            bcnt <= '0;
          end
          ST_HDR: begin
            hdr  <= hdr_nx[HDR_BITS-2:0];
            bcnt <= bcnt + 1'b1;
            if (bcnt == HDR_LAST) begin
              bcnt      <= '0;
              op_q      <= op_nx;
              reg_a     <= hdr_nx[ADR_W-1:0];
              sel_own   <= (pa_nx == phy_addr);
              sel_bcast <= (pa_nx == '0) && (pa_nx != phy_addr);
              st        <= (op_nx == OPC_RD || op_nx == OPC_WR) ? ST_TA : ST_PRE;
            end
          end
          ST_TA: begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == '0) begin
              sh    <= rd_data;
              rd_go <= (op_q == OPC_RD) && rd_hit;
              if ((op_q == OPC_RD) && rd_hit) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              st   <= ST_DAT;
              bcnt <= '0;
              if (rd_go) begin
                mdio_o <= sh[REG_W-1];
                sh     <= {sh[REG_W-2:0], 1'b0};
              end
            end
          end
          ST_DAT: begin
            bcnt <= bcnt + 1'b1;
            if (op_q == OPC_RD) begin
              sh <= {sh[REG_W-2:0], 1'b0};
              if (bcnt == DAT_LAST) begin
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b1;
              end else if (rd_go) begin
                mdio_o <= sh[REG_W-1];
              end
            end else begin
              sh <= {sh[REG_W-2:0], bit_i};
            end
            if (bcnt == DAT_LAST) begin
              st    <= ST_PRE;
              bcnt  <= '0;
              ones  <= '0;
              rd_go <= 1'b0;
              if (op_q == OPC_WR) begin
                wr_en   <= 1'b1;
                wr_data <= {sh[REG_W-2:0], bit_i};
              end
            end
          end
          default: st <= ST_PRE;
        endcase
      end
    end
  end

  // R2
  mdio_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> ($stable(mdio_oe) && $stable(mdio_o)));

  // R2
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R3
  drive_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> (op_q == OPC_RD) && (sel_own || sel_bcast));
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter logic [15:0] OUI_HI    = 16'h2A5C,
  parameter logic [5:0]  OUI_LO    = 6'h15,
  parameter logic [5:0]  MODEL     = 6'h0C,
  parameter logic [3:0]  REV       = 4'h9,
  parameter int          VEND_BASE = 16,
  parameter int          VEND_NUM  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADR_W-1:0] reg_a,
  input  logic             sel_own,
  input  logic             sel_bcast,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [2:0]       tech_strap,
  input  logic             link_up,
  input  logic             an_done,
  output logic             rd_hit,
  output logic [REG_W-1:0] rd_data,
  output ctl_t             ctl_q
);
  localparam int VI_W = (VEND_NUM > 1) ? $clog2(VEND_NUM) : 1;
  localparam logic [ADR_W-1:0] V_LO = ADR_W'(VEND_BASE);
  localparam logic [ADR_W:0]   V_HI = (ADR_W + 1)'(VEND_BASE + VEND_NUM);
  localparam logic [ADR_W-1:0] STD_END = ADR_W'(4);

  logic [REG_W-1:0] vend [VEND_NUM];
  logic             is_std;
  logic             is_vend;
  logic [VI_W-1:0]  vidx;
  logic             wr_hit;
  logic             sw_rst_wr;
  logic             spd_wr_ok;
  logic [REG_W-1:0] ctl_word;
  logic [REG_W-1:0] stat_word;

  assign is_std    = reg_a < STD_END;
  assign is_vend   = (reg_a >= V_LO) && ({1'b0, reg_a} < V_HI);
  assign vidx      = VI_W'(reg_a - V_LO);
  assign rd_hit    = (is_std && (sel_own || sel_bcast)) || (is_vend && sel_own);
  assign wr_hit    = wr_en && rd_hit;
  assign sw_rst_wr = wr_hit && (reg_a == '0) && wr_data[15];
  assign spd_wr_ok = (tech_strap == 3'b000) && !ctl_q.an_en;

  assign ctl_word  = {1'b0, ctl_q.loopback, ctl_q.speed100, ctl_q.an_en,
                      ctl_q.pwrdn, ctl_q.isolate, 1'b0, ctl_q.duplex, 8'h00};
  assign stat_word = {1'b0, tech_strap[2], tech_strap[1], tech_strap[0], 1'b1,
                      5'b00000, an_done, 1'b0, 1'b1, link_up, 1'b0, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || sw_rst_wr) begin
      ctl_q <= CTL_DEF;
    end else if (wr_hit && (reg_a == '0)) begin
      ctl_q.loopback <= wr_data[14];
      ctl_q.an_en    <= wr_data[12];
      ctl_q.pwrdn    <= wr_data[11];
      ctl_q.isolate  <= wr_data[10];
      ctl_q.duplex   <= wr_data[8];
      if (spd_wr_ok) ctl_q.speed100 <= wr_data[13];
    end
  end

  for (genvar g = 0; g < VEND_NUM; g++) begin : g_vend
    always_ff @(posedge clk) begin
      if (rst || sw_rst_wr) vend[g] <= '0;
      else if (wr_hit && is_vend && (vidx == VI_W'(g))) vend[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (is_vend) begin
      rd_data = vend[vidx];
    end else begin
      case (reg_a)
        5'd0:    rd_data = ctl_word;
        5'd1:    rd_data = stat_word;
        5'd2:    rd_data = OUI_HI;
        5'd3:    rd_data = {OUI_LO, MODEL, REV};
        default: rd_data = '0;
      endcase
    end
  end

  // R5
  speed_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ((tech_strap != 3'b000) && !sw_rst_wr) |=> $stable(ctl_q.speed100));

  // R7
  swrst_default_chk: assert property (@(posedge clk) disable iff (rst)
    sw_rst_wr |=> (ctl_q.speed100 && ctl_q.an_en && !ctl_q.pwrdn &&
                   !ctl_q.isolate && !ctl_q.loopback && !ctl_q.duplex));

  // R4
  miss_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_hit) |=> $stable(ctl_q));
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int          PRE_LEN   = 32,
  parameter int          SYNC_STG  = 2,
  parameter logic [15:0] OUI_HI    = 16'h2A5C,
  parameter logic [5:0]  OUI_LO    = 6'h15,
  parameter logic [5:0]  MODEL     = 6'h0C,
  parameter logic [3:0]  REV       = 4'h9,
  parameter int          VEND_BASE = 16,
  parameter int          VEND_NUM  = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mdc,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic [4:0] phy_addr,
  input  logic [2:0] tech_strap,
  input  logic       link_up,
  input  logic       an_done,
  output logic       speed100,
  output logic       an_enable,
  output logic       full_duplex,
  output logic       loopback,
  output logic       power_down,
  output logic       isolate
);
  logic             rise;
  logic             bit_q;
  logic [ADR_W-1:0] reg_a;
  logic             sel_own;
  logic             sel_bcast;
  logic             wr_en;
  logic [REG_W-1:0] wr_data;
  logic             rd_hit;
  logic [REG_W-1:0] rd_data;
  ctl_t             ctl_q;

  mdio_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_i),
    .rise(rise), .bit_q(bit_q)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst(rst), .rise(rise), .bit_i(bit_q), .phy_addr(phy_addr),
    .rd_hit(rd_hit), .rd_data(rd_data), .reg_a(reg_a), .sel_own(sel_own),
    .sel_bcast(sel_bcast), .wr_en(wr_en), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_regfile #(
    .OUI_HI(OUI_HI), .OUI_LO(OUI_LO), .MODEL(MODEL), .REV(REV),
    .VEND_BASE(VEND_BASE), .VEND_NUM(VEND_NUM)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_a(reg_a), .sel_own(sel_own),
    .sel_bcast(sel_bcast), .wr_en(wr_en), .wr_data(wr_data),
    .tech_strap(tech_strap), .link_up(link_up), .an_done(an_done),
    .rd_hit(rd_hit), .rd_data(rd_data), .ctl_q(ctl_q)
  );

  assign speed100    = ctl_q.speed100;
  assign an_enable   = ctl_q.an_en;
  assign full_duplex = ctl_q.duplex;
  assign loopback    = ctl_q.loopback;
  assign power_down  = ctl_q.pwrdn;
  assign isolate     = ctl_q.isolate;
endmodule

// File: tb/mdio_mgmt_slave_tb_top.sv
module mdio_mgmt_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_MDC   = 8;
  localparam logic [4:0] MY_ADDR = 5'd9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mdc = 1'b0;
  logic       mdio_i = 1'b1;
  logic       mdio_o, mdio_oe;
  logic [2:0] tech_strap = 3'b101;
  logic       link_up = 1'b1;
  logic       an_done = 1'b0;
  logic       speed100, an_enable, full_duplex, loopback, power_down, isolate;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] val;
    bit          drv;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  logic [15:0] cap_val;
  bit cap_ta1_off, cap_ta2_ok, cap_all, cap_none, cap_rel;
  event rd_evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_slave #(
    .PRE_LEN(32), .SYNC_STG(2), .OUI_HI(16'h2A5C), .OUI_LO(6'h15),
    .MODEL(6'h0C), .REV(4'h9), .VEND_BASE(16), .VEND_NUM(7)
  ) dut_i (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .phy_addr(MY_ADDR), .tech_strap(tech_strap),
    .link_up(link_up), .an_done(an_done), .speed100(speed100),
    .an_enable(an_enable), .full_duplex(full_duplex), .loopback(loopback),
    .power_down(power_down), .isolate(isolate)
  );

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mbit(logic b, output logic s_oe, output logic s_o);
    mdio_i = b;
    tick(HALF_MDC);
    s_oe = mdio_oe;
    s_o  = mdio_o;
    mdc  = 1'b1;
    tick(HALF_MDC);
    mdc  = 1'b0;
  endtask

  task automatic hdr(int npre, logic [1:0] op, logic [4:0] pa, logic [4:0] ra);
    logic a, b;
    for (int i = 0; i < npre; i++) mbit(1'b1, a, b);
    mbit(1'b0, a, b);
    mbit(1'b1, a, b);
    for (int i = 1; i >= 0; i--) mbit(op[i], a, b);
    for (int i = 4; i >= 0; i--) mbit(pa[i], a, b);
    for (int i = 4; i >= 0; i--) mbit(ra[i], a, b);
  endtask

  task automatic do_read(logic [4:0] pa, logic [4:0] ra, logic [15:0] exp,
                         bit drv, string tag, int npre = 32);
    exp_t e;
    logic oe, o;
    e.val = exp; e.drv = drv; e.tag = tag;
    sbq.push_back(e);
    hdr(npre, 2'b10, pa, ra);
    mbit(1'b1, oe, o);
    cap_ta1_off = !oe;
    mbit(1'b1, oe, o);
    cap_ta2_ok = oe && !o;
    cap_none   = !oe;
    cap_all    = oe;
    for (int i = 15; i >= 0; i--) begin
      mbit(1'b1, oe, o);
      cap_val[i] = oe ? o : 1'b1;
      cap_all    = cap_all && oe;
      cap_none   = cap_none && !oe;
    end
    mbit(1'b1, oe, o);
    cap_rel = !oe;
    -> rd_evt;
    tick(2);
  endtask

  task automatic do_write(logic [4:0] pa, logic [4:0] ra, logic [15:0] d,
                          logic [1:0] op = 2'b01);
    logic a, b;
    hdr(32, op, pa, ra);
    mbit(1'b1, a, b);
    mbit(1'b0, a, b);
    for (int i = 15; i >= 0; i--) mbit(d[i], a, b);
    mbit(1'b1, a, b);
    tick(4);
  endtask

  function automatic logic [15:0] ctl_pins();
    return {10'd0, loopback, speed100, an_enable, power_down, isolate, full_duplex};
  endfunction

  initial begin : monitor
    forever begin
      exp_t e;
      @(rd_evt);
      if (sbq.size() == 0) begin
        chk(1'b0, "scoreboard underflow", cap_val, 16'h0);
      end else begin
        e = sbq.pop_front();
        if (e.drv)
          chk(cap_ta1_off && cap_ta2_ok && cap_all && cap_rel && (cap_val == e.val),
              e.tag, cap_val, e.val);
        else
          chk(cap_none && cap_ta1_off, e.tag, cap_val, 16'hFFFF);
      end
    end
  end

  initial begin : watchdog
    tick(150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    tick(6);
    rst = 1'b0;
    tick(4);
    // R5 R6: reset values, order {lb,spd,an,pd,iso,dup}
    chk(ctl_pins() == 16'h0018, "R5 R6 reset outputs", ctl_pins(), 16'h0018);
    chk(mdio_oe == 1'b0, "R2 idle release", {15'd0, mdio_oe}, 16'h0);

    do_read(MY_ADDR, 5'd0, 16'h3000, 1, "R2 R5 control read");
    do_read(MY_ADDR, 5'd1, 16'h580D, 1, "R8 status with straps 101");
    do_read(MY_ADDR, 5'd2, 16'h2A5C, 1, "R9 id high");
    do_read(MY_ADDR, 5'd3, 16'h54C9, 1, "R9 id low");

    do_write(MY_ADDR, 5'd0, 16'h0000);
    do_read(MY_ADDR, 5'd0, 16'h2000, 1, "R5 speed locked by straps");
    tech_strap = 3'b000;
    do_write(MY_ADDR, 5'd0, 16'h0000);
    do_read(MY_ADDR, 5'd0, 16'h0000, 1, "R5 speed writable");
    chk(speed100 == 1'b0, "R5 speed pin", {15'd0, speed100}, 16'h0);
    do_write(MY_ADDR, 5'd0, 16'h1000);
    do_write(MY_ADDR, 5'd0, 16'h2000);
    do_read(MY_ADDR, 5'd0, 16'h0000, 1, "R5 speed locked by held autoneg");

    do_read(MY_ADDR, 5'd1, 16'h080D, 1, "R8 status after control writes");
    an_done = 1'b1;
    do_read(MY_ADDR, 5'd1, 16'h082D, 1, "R8 status autoneg done");

    do_write(MY_ADDR, 5'd0, 16'h4D00);
    chk(ctl_pins() == 16'h0027, "R6 control outputs", ctl_pins(), 16'h0027);
    do_read(MY_ADDR, 5'd0, 16'h4D00, 1, "R6 answers while isolated");
    do_read(5'd0, 5'd0, 16'h4D00, 1, "R3 broadcast standard read");

    do_write(MY_ADDR, 5'd17, 16'hBEEF);
    do_read(MY_ADDR, 5'd17, 16'hBEEF, 1, "R10 vendor write/read");
    do_read(MY_ADDR, 5'd22, 16'h0000, 1, "R10 last vendor default");
    do_read(MY_ADDR, 5'd16, 16'h0000, 1, "R10 first vendor default");
    do_read(5'd0, 5'd17, 16'hFFFF, 0, "R3 broadcast vendor read undriven");
    do_write(5'd0, 5'd17, 16'h1234);
    do_read(MY_ADDR, 5'd17, 16'hBEEF, 1, "R3 broadcast vendor write ignored");
    do_read(5'd3, 5'd0, 16'hFFFF, 0, "R3 foreign address ignored");
    do_write(5'd3, 5'd17, 16'h5555);
    do_read(MY_ADDR, 5'd17, 16'hBEEF, 1, "R3 foreign write ignored");

    do_read(MY_ADDR, 5'd5, 16'hFFFF, 0, "R4 unimplemented 5");
    do_read(MY_ADDR, 5'd15, 16'hFFFF, 0, "R4 unimplemented 15");
    do_read(MY_ADDR, 5'd23, 16'hFFFF, 0, "R4 unimplemented 23");
    do_write(MY_ADDR, 5'd4, 16'hFFFF);
    chk(ctl_pins() == 16'h0027, "R4 unimplemented write inert", ctl_pins(), 16'h0027);

    begin
      logic a, b;
      mbit(1'b0, a, b);
    end
    do_read(MY_ADDR, 5'd0, 16'hFFFF, 0, "R1 31-bit preamble rejected", 31);
    do_read(MY_ADDR, 5'd0, 16'h4D00, 1, "R1 32-bit preamble accepted");
    do_write(MY_ADDR, 5'd17, 16'h0F0F, 2'b00);
    do_write(MY_ADDR, 5'd17, 16'h0F0F, 2'b11);
    do_read(MY_ADDR, 5'd17, 16'hBEEF, 1, "R1 bad opcodes ignored");

    do_write(MY_ADDR, 5'd0, 16'h8000);
    chk(ctl_pins() == 16'h0018, "R7 soft reset outputs", ctl_pins(), 16'h0018);
    do_read(MY_ADDR, 5'd0, 16'h3000, 1, "R7 control after soft reset");
    do_read(MY_ADDR, 5'd17, 16'h0000, 1, "R7 vendor cleared");

    tick(4);
    chk(sbq.size() == 0, "scoreboard drained", 16'(sbq.size()), 16'h0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule